// File: doc/BRIEF.md
# Dual-Link Pixel Router for LVDS Transmit Ports

This block sits between a display pipeline and one or two LVDS link ports. It accepts a parallel pixel stream in which every beat carries four logical data channels plus horizontal sync, vertical sync and display-enable. It produces two registered link words, a primary and a companion, each made of four lane slots and a four-bit control nibble. The 7:1 serialiser, the analogue PHY and the bit packing inside each lane are downstream and are not part of this block.

In single-link operation every beat is forwarded to the primary port and the companion port stays idle. In dual-link (vertical stripe) operation consecutive active pixels of a line are paired. One pixel of each pair goes to the primary port and the other to the companion port, so each port runs at half the input pixel rate. The pairing order can be reversed, but only when the router is configured as the primary instance. A lane remap option crosses lanes 1 and 3 on both ports. The block also reports a lane-format code that tells the downstream packer which bit layout to use.

Configuration is captured only while the router is stopped, so a running frame never sees a mode change.

Top module: `lvds_pair_router`

## Requirements
- R1: After reset both `pri_valid` and `sec_valid` are low, and `lane_fmt` is 0.
- R2: Configuration inputs are captured on every clock edge at which `run` is low and are held while `run` is high. Changes made while running affect neither `lane_fmt` nor routing.
- R3: With link type 0 (single link), every beat with `in_valid` high appears on the primary port on the clock edge that samples it (`pri_valid` is high after that edge), and `sec_valid` stays low.
- R4: With link type 1, the active pixels of a line are numbered from 0. Pixel 2k is held back. On the edge that samples pixel 2k+1, both ports go valid together, with the even pixel on the primary port and the odd pixel on the companion port. No output beat is produced for the even pixel alone.
- R5: With link type 2 and `cfg_companion` low, the pairing is reversed: the odd pixel goes to the primary port and the even pixel to the companion port.
- R6: With `cfg_companion` high, the reversal request of link type 2 is ignored and the routing is the same as for link type 1.
- R7: The control nibble carries hsync in bit 0, vsync in bit 1 and display-enable in bit 2, with bit 3 always 0. On a dual-link beat, both ports carry the same nibble, taken from the beat that completes the output.
- R8: A rising edge of `in_hsync` on a valid beat starts a new line. That beat becomes pixel 0, and any half-pair still held back is discarded.
- R9: With `cfg_lane_x13` high, the logical channels 0, 1, 2, 3 (each LANE_W bits, channel 0 at the LSBs) are placed on physical lanes 0, 3, 2, 1. With it low, the mapping is the identity.
- R10: `lane_fmt` is 0 for the JEIDA-style layout and 4 for the VESA-style layout, with 1 ORed in when mirrored (LSB-to-MSB) order is selected.
- R11: In dual-link mode, a valid beat with display-enable low is sent at once to both ports with zeroed lanes and its control nibble. It also drops any pending half-pair.
- R12: While `run` is low, no output beat is produced, whatever `in_valid` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Router running; configuration is captured while low |
| cfg_link_type | input | 2 | 0 single, 1 dual even-first, 2 dual odd-first |
| cfg_companion | input | 1 | Router is the companion instance; ordering reversal is ignored |
| cfg_lane_x13 | input | 1 | Cross lanes 1 and 3 |
| cfg_vesa | input | 1 | Select the VESA-style lane layout |
| cfg_mirror | input | 1 | Select mirrored bit order |
| in_valid | input | 1 | Input beat valid |
| in_hsync | input | 1 | Horizontal sync |
| in_vsync | input | 1 | Vertical sync |
| in_de | input | 1 | Display enable (active pixel) |
| in_pixel | input | 4*LANE_W | Four logical channels, channel 0 at the LSBs |
| pri_valid | output | 1 | Primary port beat valid |
| pri_lanes | output | 4*LANE_W | Primary port lane slots |
| pri_ctrl | output | 4 | Primary port control nibble |
| sec_valid | output | 1 | Companion port beat valid |
| sec_lanes | output | 4*LANE_W | Companion port lane slots |
| sec_ctrl | output | 4 | Companion port control nibble |
| lane_fmt | output | 3 | Lane-format code for the downstream packer |

## Verification
The bench attacks the pairing order under all three link types and both instance roles. A design that honours the reversal on the companion would put the odd pixel on the primary port, and one that emits on every pixel would show a valid beat one cycle early. It starts a line with a held-back half-pair and checks that the hsync edge, not the next pixel, defines pixel 0. A design that keeps stale parity would pair the wrong pixels. Blanking beats in the middle of a pair, configuration changes while running, and the lane 1/3 cross are each checked at the ports. These catch a pending pixel that leaks into the next pair, a mode that changes mid-frame, and a remap that swaps the wrong lanes.

// File: rtl/lvds_router_pkg.sv
package lvds_router_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    LINK_SINGLE     = 2'd0,
    LINK_EVEN_FIRST = 2'd1,
    LINK_ODD_FIRST  = 2'd2
  } link_mode_e;

  localparam logic [2:0] FMT_JEIDA  = 3'd0;
  localparam logic [2:0] FMT_VESA   = 3'd4;
  localparam logic [2:0] FMT_MIRROR = 3'd1;

  localparam int CTRL_HS = 0;
  localparam int CTRL_VS = 1;
  localparam int CTRL_DE = 2;
  localparam int CTRL_W  = 4;

  typedef struct packed {
    logic       dual;
    logic       swap;
    logic       x13;
    logic [2:0] fmt;
  } router_cfg_t;
endpackage

// File: rtl/lvds_cfg_latch.sv
module lvds_cfg_latch
  import lvds_router_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic [1:0]  link_type,
  input  logic        companion,
  input  logic        lane_x13,
  input  logic        vesa,
  input  logic        mirror,
  output router_cfg_t cfg_q
);
  router_cfg_t cfg_d;
  logic        cfg_en;

  always_comb begin
    cfg_en     = !run;
    cfg_d.dual = (link_type != LINK_SINGLE);
    cfg_d.swap = (link_type == LINK_ODD_FIRST) && !companion;
    cfg_d.x13  = lane_x13;
    cfg_d.fmt  = (vesa ? FMT_VESA : FMT_JEIDA) | (mirror ? FMT_MIRROR : 3'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  // R2: captured configuration frozen while running
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(cfg_q));
endmodule

// File: rtl/lvds_line_pairer.sv
module lvds_line_pairer
  import lvds_router_pkg::*;
#(
  parameter int LANE_W = 7,
  localparam int DW = LANES * LANE_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              dual,
  input  logic              swap,
  input  logic              in_valid,
  input  logic              in_hsync,
  input  logic              in_vsync,
  input  logic              in_de,
  input  logic [DW-1:0]     in_pixel,
  output logic              emit_pri,
  output logic              emit_sec,
  output logic [DW-1:0]     pix_pri,
  output logic [DW-1:0]     pix_sec,
  output logic [CTRL_W-1:0] ctrl
);
  logic          idx_q, idx_d;
  logic          hs_prev_q, hs_prev_d;
  logic [DW-1:0] hold_q, hold_d;
  logic          hold_en;
  logic          hs_rise;
  logic          idx_eff;
  logic          beat;

  always_comb begin
    beat      = run && in_valid;
    hs_rise   = beat && in_hsync && !hs_prev_q;
    idx_eff   = hs_rise ? 1'b0 : idx_q;
    idx_d     = idx_q;
    hs_prev_d = hs_prev_q;
    hold_d    = in_pixel;
    hold_en   = 1'b0;
    emit_pri  = 1'b0;
    emit_sec  = 1'b0;
    pix_pri   = '0;
    pix_sec   = '0;
    ctrl      = '0;
    ctrl[CTRL_HS] = in_hsync;
    ctrl[CTRL_VS] = in_vsync;
    ctrl[CTRL_DE] = in_de;

    if (!run) begin
      idx_d     = 1'b0;
      hs_prev_d = 1'b0;
    end else if (in_valid) begin
      hs_prev_d = in_hsync;
      if (!dual) begin
        emit_pri = 1'b1;
        pix_pri  = in_de ? in_pixel : '0;
        idx_d    = 1'b0;
      end else if (!in_de) begin
        emit_pri = 1'b1;
        emit_sec = 1'b1;
        idx_d    = 1'b0;
      end else if (!idx_eff) begin
        hold_en = 1'b1;
        idx_d   = 1'b1;
      end else begin
        emit_pri = 1'b1;
        emit_sec = 1'b1;
        pix_pri  = swap ? in_pixel : hold_q;
        pix_sec  = swap ? hold_q : in_pixel;
        idx_d    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= 1'b0;
      hs_prev_q <= 1'b0;
    end else begin
      idx_q     <= idx_d;
      hs_prev_q <= hs_prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  // R8: an active pixel on an hsync rising edge is pixel 0 and is held
  p_line_start_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dual && in_valid && in_de && hs_rise) |=> idx_q);

  // R4: a dual-link pair only completes on an odd pixel
  p_pair_on_odd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dual && in_valid && in_de && emit_sec) |-> (idx_q && !hs_rise));
endmodule

// File: rtl/lvds_lane_remap.sv
module lvds_lane_remap
  import lvds_router_pkg::*;
#(
  parameter int LANE_W = 7,
  localparam int DW = LANES * LANE_W
)(
  input  logic          x13,
  input  logic [DW-1:0] logical,
  output logic [DW-1:0] physical
);
  for (genvar p = 0; p < LANES; p++) begin : g_lane
    localparam int SRC = (p % 2 == 1) ? (LANES - p) : p;
    assign physical[p*LANE_W +: LANE_W] =
      x13 ? logical[SRC*LANE_W +: LANE_W] : logical[p*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/lvds_pair_router.sv
module lvds_pair_router
  import lvds_router_pkg::*;
#(
  parameter int LANE_W = 7,
  localparam int DW = LANES * LANE_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [1:0]        cfg_link_type,
  input  logic              cfg_companion,
  input  logic              cfg_lane_x13,
  input  logic              cfg_vesa,
  input  logic              cfg_mirror,
  input  logic              in_valid,
  input  logic              in_hsync,
  input  logic              in_vsync,
  input  logic              in_de,
  input  logic [DW-1:0]     in_pixel,
  output logic              pri_valid,
  output logic [DW-1:0]     pri_lanes,
  output logic [CTRL_W-1:0] pri_ctrl,
  output logic              sec_valid,
  output logic [DW-1:0]     sec_lanes,
  output logic [CTRL_W-1:0] sec_ctrl,
  output logic [2:0]        lane_fmt
);
  router_cfg_t       cfg_q;
  logic              emit_pri, emit_sec;
  logic [DW-1:0]     pix_pri, pix_sec;
  logic [CTRL_W-1:0] ctrl;
  logic [DW-1:0]     phys [2];
  logic [DW-1:0]     logi [2];

  lvds_cfg_latch u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .link_type (cfg_link_type),
    .companion (cfg_companion),
    .lane_x13  (cfg_lane_x13),
    .vesa      (cfg_vesa),
    .mirror    (cfg_mirror),
    .cfg_q     (cfg_q)
  );

  lvds_line_pairer #(.LANE_W(LANE_W)) u_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .dual     (cfg_q.dual),
    .swap     (cfg_q.swap),
    .in_valid (in_valid),
    .in_hsync (in_hsync),
    .in_vsync (in_vsync),
    .in_de    (in_de),
    .in_pixel (in_pixel),
    .emit_pri (emit_pri),
    .emit_sec (emit_sec),
    .pix_pri  (pix_pri),
    .pix_sec  (pix_sec),
    .ctrl     (ctrl)
  );

  assign logi[0] = pix_pri;
  assign logi[1] = pix_sec;

  for (genvar l = 0; l < 2; l++) begin : g_link
    lvds_lane_remap #(.LANE_W(LANE_W)) u_remap (
      .x13      (cfg_q.x13),
      .logical  (logi[l]),
      .physical (phys[l])
    );
  end

  assign lane_fmt = cfg_q.fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_valid <= 1'b0;
      sec_valid <= 1'b0;
    end else begin
      pri_valid <= emit_pri;
      sec_valid <= emit_sec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_lanes <= '0;
      pri_ctrl  <= '0;
    end else if (emit_pri) begin
      pri_lanes <= phys[0];
      pri_ctrl  <= ctrl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_lanes <= '0;
      sec_ctrl  <= '0;
    end else if (emit_sec) begin
      sec_lanes <= phys[1];
      sec_ctrl  <= ctrl;
    end
  end

  // R3: single link keeps the companion port idle
  p_single_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cfg_q.dual) |=> !sec_valid);

  // R12: nothing leaves while stopped
  p_stopped_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!pri_valid && !sec_valid));

  // R7: dual-link beats carry one control nibble on both ports, bit 3 clear
  p_ctrl_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_valid && sec_valid) |-> (pri_ctrl == sec_ctrl && !pri_ctrl[3]));

  // R4: the companion never runs alone
  p_sec_with_pri_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_valid |-> pri_valid);
endmodule

// File: tb/lvds_pair_router_tb.sv
module lvds_pair_router_tb;
  localparam int LW = 7;
  localparam int DW = 4 * LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          run;
  logic [1:0]    cfg_link_type;
  logic          cfg_companion, cfg_lane_x13, cfg_vesa, cfg_mirror;
  logic          in_valid, in_hsync, in_vsync, in_de;
  logic [DW-1:0] in_pixel;
  logic          pri_valid, sec_valid;
  logic [DW-1:0] pri_lanes, sec_lanes;
  logic [3:0]    pri_ctrl, sec_ctrl;
  logic [2:0]    lane_fmt;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lvds_pair_router #(.LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cfg_link_type(cfg_link_type), .cfg_companion(cfg_companion),
    .cfg_lane_x13(cfg_lane_x13), .cfg_vesa(cfg_vesa), .cfg_mirror(cfg_mirror),
    .in_valid(in_valid), .in_hsync(in_hsync), .in_vsync(in_vsync),
    .in_de(in_de), .in_pixel(in_pixel),
    .pri_valid(pri_valid), .pri_lanes(pri_lanes), .pri_ctrl(pri_ctrl),
    .sec_valid(sec_valid), .sec_lanes(sec_lanes), .sec_ctrl(sec_ctrl),
    .lane_fmt(lane_fmt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic v, input logic de, input logic hs, input logic vs,
                      input logic [DW-1:0] d);
    in_valid = v; in_de = de; in_hsync = hs; in_vsync = vs; in_pixel = d;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] lt, input logic comp, input logic x13,
                         input logic vesa, input logic mir);
    run = 1'b0;
    cfg_link_type = lt; cfg_companion = comp; cfg_lane_x13 = x13;
    cfg_vesa = vesa; cfg_mirror = mir;
    beat(1'b0, 1'b0, 1'b0, 1'b0, '0);
    beat(1'b0, 1'b0, 1'b0, 1'b0, '0);
    run = 1'b1;
  endtask

  function automatic logic [DW-1:0] cross13(input logic [DW-1:0] d);
    return {d[LW-1+LW:LW], d[3*LW-1:2*LW], d[4*LW-1:3*LW], d[LW-1:0]};
  endfunction

  task automatic t_reset();
    chk("R1 pri_valid", pri_valid, 0);
    chk("R1 sec_valid", sec_valid, 0);
    chk("R1 lane_fmt", lane_fmt, 0);
  endtask

  task automatic t_format();
    set_cfg(2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10 vesa mirrored", lane_fmt, 5);
    cfg_vesa = 1'b0; cfg_mirror = 1'b0; cfg_link_type = 2'd0;
    beat(1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk("R2 fmt held while running", lane_fmt, 5);
    beat(1'b1, 1'b1, 1'b0, 1'b0, 28'h1111111);
    chk("R2 still dual: no beat on first pixel", pri_valid, 0);
    beat(1'b1, 1'b1, 1'b0, 1'b0, 28'h2222222);
    chk("R2 still dual: companion valid", sec_valid, 1);
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 jeida mirrored", lane_fmt, 1);
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 jeida plain", lane_fmt, 0);
  endtask

  task automatic t_single();
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    beat(1'b1, 1'b1, 1'b0, 1'b1, 28'hABCDEF1);
    chk("R3 pri valid", pri_valid, 1);
    chk("R3 pri data", pri_lanes, 28'hABCDEF1);
    chk("R3 sec idle", sec_valid, 0);
    chk("R7 ctrl de+vs", pri_ctrl, 4'b0110);
    beat(1'b1, 1'b1, 1'b1, 1'b0, 28'h0123456);
    chk("R3 second pixel", pri_lanes, 28'h0123456);
    chk("R7 ctrl de+hs", pri_ctrl, 4'b0101);
    chk("R9 identity without cross", pri_lanes, 28'h0123456);
    beat(1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk("R3 no beat without valid", pri_valid, 0);
  endtask

  task automatic t_dual(input logic [1:0] lt, input logic comp, input bit odd_first,
                        input string req);
    set_cfg(lt, comp, 1'b0, 1'b0, 1'b0);
    beat(1'b1, 1'b1, 1'b0, 1'b0, 28'h00000AA);
    chk({req, " no beat on even pixel"}, pri_valid, 0);
    beat(1'b1, 1'b1, 1'b0, 1'b1, 28'h00000BB);
    chk({req, " pri valid"}, pri_valid, 1);
    chk({req, " sec valid"}, sec_valid, 1);
    chk({req, " pri data"}, pri_lanes, odd_first ? 28'h00000BB : 28'h00000AA);
    chk({req, " sec data"}, sec_lanes, odd_first ? 28'h00000AA : 28'h00000BB);
    chk("R7 pri ctrl from completing beat", pri_ctrl, 4'b0110);
    chk("R7 sec ctrl equal", sec_ctrl, 4'b0110);
    beat(1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk({req, " one beat per pair"}, pri_valid, 0);
  endtask

  task automatic t_hsync();
    set_cfg(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    beat(1'b1, 1'b1, 1'b0, 1'b0, 28'h0000011);
    beat(1'b1, 1'b1, 1'b1, 1'b0, 28'h0000022);
    chk("R8 hsync edge restarts pair", pri_valid, 0);
    beat(1'b1, 1'b1, 1'b1, 1'b0, 28'h0000033);
    chk("R8 pair valid", sec_valid, 1);
    chk("R8 pri is line pixel 0", pri_lanes, 28'h0000022);
    chk("R8 sec is line pixel 1", sec_lanes, 28'h0000033);
  endtask

  task automatic t_blank();
    set_cfg(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    beat(1'b1, 1'b1, 1'b0, 1'b0, 28'h0000044);
    beat(1'b1, 1'b0, 1'b1, 1'b0, 28'hFFFFFFF);
    chk("R11 blank on pri", pri_valid, 1);
    chk("R11 blank on sec", sec_valid, 1);
    chk("R11 blank data zero", pri_lanes | sec_lanes, 0);
    chk("R11 blank ctrl", sec_ctrl, 4'b0001);
    beat(1'b1, 1'b1, 1'b1, 1'b0, 28'h0000055);
    chk("R11 pending dropped", pri_valid, 0);
    beat(1'b1, 1'b1, 1'b1, 1'b0, 28'h0000066);
    chk("R11 next pair pri", pri_lanes, 28'h0000055);
    chk("R11 next pair sec", sec_lanes, 28'h0000066);
  endtask

  task automatic t_remap();
    set_cfg(2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    beat(1'b1, 1'b1, 1'b0, 1'b0, {7'h44, 7'h33, 7'h22, 7'h11});
    chk("R9 lanes 1 and 3 crossed", pri_lanes, {7'h22, 7'h33, 7'h44, 7'h11});
    chk("R9 bench cross", pri_lanes, cross13({7'h44, 7'h33, 7'h22, 7'h11}));
  endtask

  task automatic t_stopped();
    run = 1'b0;
    beat(1'b1, 1'b1, 1'b0, 1'b0, 28'h0000077);
    chk("R12 pri quiet", pri_valid, 0);
    chk("R12 sec quiet", sec_valid, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b0;
    cfg_link_type = 2'd0; cfg_companion = 1'b0; cfg_lane_x13 = 1'b0;
    cfg_vesa = 1'b0; cfg_mirror = 1'b0;
    in_valid = 1'b0; in_hsync = 1'b0; in_vsync = 1'b0; in_de = 1'b0; in_pixel = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_format();
    t_single();
    t_dual(2'd1, 1'b0, 1'b0, "R4");
    t_dual(2'd2, 1'b0, 1'b1, "R5");
    t_dual(2'd2, 1'b1, 1'b0, "R6");
    t_hsync();
    t_blank();
    t_remap();
    t_stopped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule